// File: doc/BRIEF.md
# Cell Striping Transmitter for a Link Group

This block accepts one stream of fixed-length cells and deals whole cells out to a group of serial links, one cell per link in turn. The group has 2 or 8 links, chosen by a parameter. Each cell leaves on its link as a one-byte link header followed by the payload bytes. The header holds an idle marker and the sequence number of that link. A receiver at the far end uses the sequence numbers to line the links up again and rebuild the original cell order.

Each link has its own 7-bit sequence counter. A counter advances once for every cell placed on its link, whether the cell carries data or is idle. A frame-start pulse is held until the next cell boundary. At that boundary it clears every counter and sends the turn back to link 0. As a result, the n-th cell of a frame carries the same sequence value on every link. If no user cell is waiting when a link's turn comes, or the idle-insert input is high at that moment, the block sends an idle cell instead. An idle cell uses up the turn and the sequence number in the same way as a user cell.

The block emits exactly one byte per clock. Each cell slot lasts 1 + CELL_BYTES cycles. The outputs are registered, so a byte appears on its link one cycle after the slot cycle that produced it.

Top module: `mls_stripe_tx`

## Requirements
- R1: Cell headers go to the links in strict rotation 0, 1, …, NUM_LINKS-1, 0, … (NUM_LINKS is 2 or 8). Only a frame start breaks the rotation; it forces the next cell to link 0.
- R2: Bit 7 of the header byte is the idle marker: 0 for a user cell, 1 for an idle cell. A slot carries an idle cell when, at its header cycle, the input does not present a start-of-cell byte (in_valid and in_sop both high) or idle_force is high.
- R3: Bits 6:0 of the header byte hold the link's sequence number. On each link it rises by 1 with every cell that link sends, user or idle, independently of the other links. It wraps from 127 to 0.
- R4: A frame_start pulse is remembered until the next header cycle, including a pulse that falls on the header cycle itself. That header goes to link 0 with sequence 0, and the next cell on every other link also carries sequence 0. A second pulse within the same cell has no further effect.
- R5: Every cell on a link is one byte with lane_sop high (the header), followed by CELL_BYTES bytes with lane_sop low. A user cell carries the accepted input bytes in order. An idle cell carries 0x00 bytes.
- R6: in_ready is high only in the payload cycles of a user cell. It is low in every header cycle and throughout an idle cell.
- R7: After reset is released, exactly one bit of lane_valid is high in every cycle, and lane_sop is never high on a link whose lane_valid is low.
- R8: While reset is high, lane_valid, lane_sop and in_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame-boundary pulse |
| idle_force | input | 1 | Forces an idle cell at the next header cycle |
| in_valid | input | 1 | Input byte valid |
| in_sop | input | 1 | Input byte is the first byte of a cell |
| in_data | input | 8 | Input payload byte |
| in_ready | output | 1 | Input byte is taken this cycle |
| lane_valid | output | NUM_LINKS | Per-link byte valid |
| lane_sop | output | NUM_LINKS | Per-link header marker |
| lane_data | output | 8*NUM_LINKS | Per-link byte, link i in bits 8i+7:8i |

## Verification
The interesting collision is a frame start that lands exactly on a header cycle, in the same cycle that the idle-or-user decision and a counter increment are made. The bench provokes this by spacing frame pulses at intervals that are not multiples of the slot length, so they drift across every slot phase. It also sends two pulses inside one cell. A behavioural model, written as integers and arrays, predicts which link and sequence number every header carries. The design's bytes and in_ready are compared with the model on every clock, while the gap and idle-insert patterns overlap the frame pulses.

// File: rtl/mls_pkg.sv
`timescale 1ns/1ps
package mls_pkg;
    localparam int SEQ_W  = 7;
    localparam int BYTE_W = 8;

    typedef logic [SEQ_W-1:0]  seq_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        logic idle;
        seq_t seq;
    } link_hdr_t;

    typedef struct packed {
        logic  sop;
        byte_t data;
    } beat_t;

    function automatic byte_t hdr_byte(input logic idle, input seq_t seq);
        link_hdr_t h;
        h.idle = idle;
        h.seq  = seq;
        return byte_t'(h);
    endfunction
endpackage

// File: rtl/mls_slot_sched.sv
`timescale 1ns/1ps
module mls_slot_sched #(
    parameter  int NUM_LINKS  = 8,
    parameter  int CELL_BYTES = 4,
    localparam int PTR_W      = $clog2(NUM_LINKS),
    localparam int CNT_W      = $clog2(CELL_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             cell_offered,
    output logic             boundary,
    output logic             frame_take,
    output logic [PTR_W-1:0] hdr_link,
    output logic             hdr_user,
    output logic [PTR_W-1:0] body_link,
    output logic             body_user
);
    localparam logic [CNT_W-1:0] LAST_POS  = CNT_W'(CELL_BYTES);
    localparam logic [PTR_W-1:0] LAST_LINK = PTR_W'(NUM_LINKS - 1);

    logic [CNT_W-1:0] pos_q;
    logic [PTR_W-1:0] ptr_q;
    logic             pend_q;

    always_comb begin
        boundary   = (pos_q == '0);
        frame_take = boundary && (pend_q || frame_start);
        hdr_link   = frame_take ? '0 : ptr_q;
        hdr_user   = cell_offered;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            ptr_q     <= '0;
            pend_q    <= 1'b0;
            body_link <= '0;
            body_user <= 1'b0;
        end else if (boundary) begin
            body_link <= hdr_link;
            body_user <= hdr_user;
            ptr_q     <= (hdr_link == LAST_LINK) ? '0 : hdr_link + 1'b1;
            pend_q    <= 1'b0;
            pos_q     <= CNT_W'(1);
        end else begin
            pos_q <= (pos_q == LAST_POS) ? '0 : pos_q + 1'b1;
            if (frame_start) pend_q <= 1'b1;
        end
    end
endmodule

// File: rtl/mls_seq_bank.sv
`timescale 1ns/1ps
module mls_seq_bank
    import mls_pkg::*;
#(
    parameter  int NUM_LINKS = 8,
    localparam int PTR_W     = $clog2(NUM_LINKS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bump,
    input  logic             frame_take,
    input  logic [PTR_W-1:0] hdr_link,
    output seq_t             hdr_seq
);
    seq_t cnt_q [NUM_LINKS];

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[i] <= '0;
            end else if (bump) begin
                if (frame_take)
                    cnt_q[i] <= (hdr_link == PTR_W'(i)) ? seq_t'(1) : '0;
                else if (hdr_link == PTR_W'(i))
                    cnt_q[i] <= cnt_q[i] + seq_t'(1);
            end
        end
    end

    assign hdr_seq = frame_take ? '0 : cnt_q[hdr_link];
endmodule

// File: rtl/mls_lane_drive.sv
`timescale 1ns/1ps
module mls_lane_drive
    import mls_pkg::*;
#(
    parameter  int NUM_LINKS = 8,
    localparam int PTR_W     = $clog2(NUM_LINKS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PTR_W-1:0]       beat_link,
    input  beat_t                  beat,
    output logic [NUM_LINKS-1:0]   lane_valid,
    output logic [NUM_LINKS-1:0]   lane_sop,
    output logic [8*NUM_LINKS-1:0] lane_data
);
    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_lane
        logic hit;
        assign hit = (beat_link == PTR_W'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                lane_valid[i]        <= 1'b0;
                lane_sop[i]          <= 1'b0;
                lane_data[8*i +: 8]  <= '0;
            end else begin
                lane_valid[i] <= hit;
                lane_sop[i]   <= hit && beat.sop;
                if (hit) lane_data[8*i +: 8] <= beat.data;
            end
        end
    end
endmodule

// File: rtl/mls_stripe_tx.sv
`timescale 1ns/1ps
module mls_stripe_tx
    import mls_pkg::*;
#(
    parameter  int NUM_LINKS  = 8,
    parameter  int CELL_BYTES = 4,
    localparam int PTR_W      = $clog2(NUM_LINKS)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   frame_start,
    input  logic                   idle_force,
    input  logic                   in_valid,
    input  logic                   in_sop,
    input  logic [7:0]             in_data,
    output logic                   in_ready,
    output logic [NUM_LINKS-1:0]   lane_valid,
    output logic [NUM_LINKS-1:0]   lane_sop,
    output logic [8*NUM_LINKS-1:0] lane_data
);
    logic             boundary;
    logic             frame_take;
    logic             cell_offered;
    logic [PTR_W-1:0] hdr_link;
    logic             hdr_user;
    logic [PTR_W-1:0] body_link;
    logic             body_user;
    seq_t             hdr_seq;
    logic [PTR_W-1:0] beat_link;
    beat_t            beat;

    assign cell_offered = in_valid && in_sop && !idle_force;

    mls_slot_sched #(.NUM_LINKS(NUM_LINKS), .CELL_BYTES(CELL_BYTES)) u_sched (
        .clk          (clk),
        .rst          (rst),
        .frame_start  (frame_start),
        .cell_offered (cell_offered),
        .boundary     (boundary),
        .frame_take   (frame_take),
        .hdr_link     (hdr_link),
        .hdr_user     (hdr_user),
        .body_link    (body_link),
        .body_user    (body_user)
    );

    mls_seq_bank #(.NUM_LINKS(NUM_LINKS)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .bump       (boundary),
        .frame_take (frame_take),
        .hdr_link   (hdr_link),
        .hdr_seq    (hdr_seq)
    );

    always_comb begin
        if (boundary) begin
            beat_link = hdr_link;
            beat.sop  = 1'b1;
            beat.data = hdr_byte(!hdr_user, hdr_seq);
        end else begin
            beat_link = body_link;
            beat.sop  = 1'b0;
            beat.data = (body_user && in_valid) ? in_data : '0;
        end
    end

    assign in_ready = !boundary && body_user;

    mls_lane_drive #(.NUM_LINKS(NUM_LINKS)) u_lanes (
        .clk        (clk),
        .rst        (rst),
        .beat_link  (beat_link),
        .beat       (beat),
        .lane_valid (lane_valid),
        .lane_sop   (lane_sop),
        .lane_data  (lane_data)
    );
endmodule

// File: rtl/mls_stripe_chk.sv
`timescale 1ns/1ps
module mls_stripe_chk #(
    parameter  int NUM_LINKS  = 8,
    parameter  int CELL_BYTES = 4,
    localparam int PTR_W      = $clog2(NUM_LINKS)
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   in_ready,
    input logic                   frame_take,
    input logic [NUM_LINKS-1:0]   lane_valid,
    input logic [NUM_LINKS-1:0]   lane_sop,
    input logic [8*NUM_LINKS-1:0] lane_data
);
    logic             armed;
    logic             frame_d;
    logic             any_sop;
    logic [PTR_W-1:0] sel_lane;
    logic [7:0]       sel_byte;
    logic [PTR_W-1:0] prev_lane;
    logic             prev_ok;

    always_comb begin
        sel_lane = '0;
        sel_byte = '0;
        for (int i = 0; i < NUM_LINKS; i++) begin
            if (lane_valid[i]) begin
                sel_lane = PTR_W'(i);
                sel_byte = lane_data[8*i +: 8];
            end
        end
        any_sop = |lane_sop;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            armed     <= 1'b0;
            frame_d   <= 1'b0;
            prev_lane <= '0;
            prev_ok   <= 1'b0;
        end else begin
            armed   <= 1'b1;
            frame_d <= frame_take;
            if (armed && any_sop) begin
                prev_lane <= sel_lane;
                prev_ok   <= 1'b1;
            end
        end
    end

    // R8
    p_quiet_reset_r8: assert property (@(posedge clk)
        rst |=> (rst -> (lane_valid == '0 && !in_ready)))
        else $error("p_quiet_reset_r8");

    // R7
    p_one_lane_r7: assert property (@(posedge clk) disable iff (rst)
        armed |-> ($countones(lane_valid) == 1 && (lane_sop & ~lane_valid) == '0))
        else $error("p_one_lane_r7");

    // R1
    p_rotation_r1: assert property (@(posedge clk) disable iff (rst)
        (armed && any_sop && prev_ok && !frame_d) |->
            sel_lane == PTR_W'((int'(prev_lane) + 1) % NUM_LINKS))
        else $error("p_rotation_r1");

    // R4
    p_frame_link0_r4: assert property (@(posedge clk) disable iff (rst)
        frame_take |=> (lane_valid[0] && lane_sop[0] && lane_data[6:0] == 7'd0))
        else $error("p_frame_link0_r4");

    // R6, R2
    p_idle_no_ready_r6: assert property (@(posedge clk) disable iff (rst)
        (armed && any_sop && sel_byte[7]) |-> !in_ready)
        else $error("p_idle_no_ready_r6");

    for (genvar i = 0; i < NUM_LINKS; i++) begin : g_seq
        logic [6:0] nxt;
        always_ff @(posedge clk) begin
            if (rst)
                nxt <= '0;
            else if (frame_d)
                nxt <= (armed && lane_sop[i]) ? 7'd1 : 7'd0;
            else if (armed && lane_sop[i])
                nxt <= lane_data[8*i +: 7] + 7'd1;
        end
        // R3
        p_seq_step_r3: assert property (@(posedge clk) disable iff (rst)
            (armed && lane_sop[i]) |-> lane_data[8*i +: 7] == (frame_d ? 7'd0 : nxt))
            else $error("p_seq_step_r3");
    end
endmodule

bind mls_stripe_tx mls_stripe_chk #(.NUM_LINKS(NUM_LINKS), .CELL_BYTES(CELL_BYTES)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_ready   (in_ready),
    .frame_take (frame_take),
    .lane_valid (lane_valid),
    .lane_sop   (lane_sop),
    .lane_data  (lane_data)
);

// File: tb/sim_mls_stripe_tx.sv
`timescale 1ns/1ps
module sim_mls_stripe_tx;
    localparam int N  = 8;
    localparam int CB = 4;
    localparam int RUN = 9000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic frame_start = 1'b0, idle_force = 1'b0;
    logic in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0] in_data = '0;
    logic in_ready;
    logic [N-1:0] lane_valid, lane_sop;
    logic [8*N-1:0] lane_data;

    always #4 clk = ~clk;   // 125 MHz

    mls_stripe_tx #(.NUM_LINKS(N), .CELL_BYTES(CB)) u0 (
        .clk(clk), .rst(rst), .frame_start(frame_start), .idle_force(idle_force),
        .in_valid(in_valid), .in_sop(in_sop), .in_data(in_data), .in_ready(in_ready),
        .lane_valid(lane_valid), .lane_sop(lane_sop), .lane_data(lane_data));

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state
    int m_pos = 0, m_ptr = 0, m_link = 0, m_user = 0, m_pend = 0;
    int m_seq [N];
    bit e_any = 0, e_hdr = 0, e_frame = 0;
    int e_link = 0, e_byte = 0;
    bit wrap_seen = 0;
    int edge_frames = 0;

    // source state
    int src_cell = 0, src_idx = 0;
    bit src_on = 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [N-1:0] ev, es;
        ev = '0; es = '0;
        if (e_any) begin
            ev[e_link] = 1'b1;
            es[e_link] = e_hdr;
        end
        chk(lane_valid == ev, "R7 R1", "lane_valid", lane_valid, ev);
        chk(lane_sop == es, "R5", "lane_sop", lane_sop, es);
        if (e_any) begin
            if (e_hdr)
                chk(lane_data[8*e_link +: 8] == 8'(e_byte),
                    e_frame ? "R4 R2 R3" : "R2 R3", "header",
                    lane_data[8*e_link +: 8], e_byte);
            else
                chk(lane_data[8*e_link +: 8] == 8'(e_byte), "R5", "payload",
                    lane_data[8*e_link +: 8], e_byte);
        end
        chk(in_ready == (m_pos != 0 && m_user != 0), "R6", "in_ready",
            in_ready, (m_pos != 0 && m_user != 0));
    endtask

    task automatic model_step();
        e_any = 1;
        if (m_pos == 0) begin
            e_frame = (m_pend != 0) || frame_start;
            if (e_frame) begin
                if (frame_start) edge_frames++;
                m_ptr = 0;
                for (int k = 0; k < N; k++) m_seq[k] = 0;
                m_pend = 0;
            end
            m_link = m_ptr;
            m_user = (in_valid && in_sop && !idle_force) ? 1 : 0;
            e_link = m_link;
            e_hdr  = 1;
            e_byte = ((m_user != 0) ? 0 : 128) + m_seq[m_link];
            if (m_seq[m_link] == 127) wrap_seen = 1;
            m_seq[m_link] = (m_seq[m_link] + 1) % 128;
            m_ptr = (m_ptr + 1) % N;
            m_pos = 1;
        end else begin
            if (frame_start) m_pend = 1;
            e_link = m_link;
            e_hdr  = 0;
            e_frame = 0;
            e_byte = (m_user != 0 && in_valid) ? int'(in_data) : 0;
            m_pos = (m_pos == CB) ? 0 : m_pos + 1;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired act=1 exp=0");
        finish_run();
    end

    initial begin
        for (int k = 0; k < N; k++) m_seq[k] = 0;
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(lane_valid == '0, "R8", "lane_valid in reset", lane_valid, 0);
        chk(lane_sop == '0, "R8", "lane_sop in reset", lane_sop, 0);
        chk(in_ready == 1'b0, "R8", "in_ready in reset", in_ready, 0);
        rst = 1'b0;
        for (int n = 0; n < RUN; n++) begin
            if (n > 0) compare();
            // frame pulses drift over all slot phases; two in one cell at 1500/1502
            frame_start = (n < 3000) && ((n % 211 == 17) || n == 1500 || n == 1502 ||
                                         (n > 0 && n % 389 == 0));
            idle_force  = (n >= 1800 && n < 2400) && (n % 23 < 7);
            if (src_idx == 0)
                src_on = !(n >= 1000 && n < 1800 && (n % 41) < 12);
            in_valid = src_on || (src_idx != 0);
            in_sop   = (src_idx == 0);
            in_data  = 8'((src_cell * 7 + src_idx * 13 + 1) & 255);
            if (in_valid && in_ready) begin
                if (src_idx == CB - 1) begin
                    src_idx = 0;
                    src_cell++;
                end else begin
                    src_idx++;
                end
            end
            model_step();
            @(negedge clk);
        end
        compare();
        chk(wrap_seen, "R3", "sequence wrap exercised", wrap_seen, 1);
        chk(edge_frames > 0, "R4", "frame on header cycle exercised", edge_frames, 1);
        chk(src_cell > 500, "R5", "user cells delivered", src_cell, 500);
        finish_run();
    end
endmodule